// File: doc/BRIEF.md
# Firmware Hub Read Target Controller

This block is the target side of a 4-bit multiplexed firmware-hub style bus, limited to read cycles. It watches an active-low frame signal and the 4-bit bus. It recognises the start code and compares the ID nibble with its strap inputs. It then collects a 28-bit address and a size code. After that it takes over the bus and returns the requested bytes, one nibble per clock.

On the memory side the block issues a single-cycle read strobe with a byte address. It expects the byte on `mem_rdata` a fixed number of cycles later, set by `MEM_LAT` (1 to 3). Bursts of 1, 2, 4, 16 or 128 bytes start on an aligned address. A flag tells the memory side whether the access targets the array or the register space.

The host owns the bus while the header is sent. The target enables its drivers through `bus_oe` only during the response. It gives the bus back at once whenever the frame signal falls.

Top module: `fwh_read_target`

## Requirements
- R1: After reset `bus_oe` and `mem_rd` are 0. A cycle begins only on a clock edge where `frame_n` is 0 and `bus_in` is 4'b1101.
- R2: The nibble in the cycle after the start is the target ID. If it differs from `id_strap`, the target never asserts `bus_oe` or `mem_rd` for that cycle.
- R3: The next 7 nibbles form a 28-bit address, sent most significant nibble first.
- R4: The nibble after the address is the size code. Codes 0, 1, 2, 4 and 7 select 2^code bytes. Any other code causes no drive and no strobe.
- R5: The burst base address has its low `code` bits forced to 0. Byte k of the burst is read from base+k.
- R6: If address bit 22 is 1, `mem_reg_sel` is 0 and address bits 20, 21 and 23 to 27 are presented as 0. If bit 22 is 0, `mem_reg_sel` is 1 and all 28 bits are presented unchanged.
- R7: Header cycles are numbered from the start cycle, which is cycle 1; the size code is cycle 10. In cycle 11 the target does not drive. In cycle 12 it drives 4'b1111.
- R8: The target drives 4'b0101 in cycles 13 and 14, then 4'b0000 in cycle 15.
- R9: Byte k is driven as its low nibble in cycle 16+2k and its high nibble in cycle 17+2k.
- R10: After the last data nibble the target drives 4'b1111 for one cycle and releases the bus for the following cycle. It then accepts a new start.
- R11: The strobe for byte k is high for one cycle, in cycle 15+2k-MEM_LAT. `mem_rdata` is sampled MEM_LAT cycles after the strobe. Two strobes are never adjacent.
- R12: If `frame_n` is 0 during a response, `bus_oe` and `mem_rd` drop in that same cycle and stay low. If the bus carries the start code in that cycle, a new cycle begins.
- R13: After an ID mismatch or an unsupported size, the target stays silent through any cycles with `frame_n` high, including ones that carry 4'b1101. It is ready again at the next start with `frame_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame signal from the host |
| bus_in | input | 4 | Nibble sampled from the bus |
| id_strap | input | 4 | Strapped target ID |
| bus_out | output | 4 | Nibble driven when `bus_oe` is high |
| bus_oe | output | 1 | Tri-state driver enable for the bus |
| mem_rd | output | 1 | Single-cycle memory read strobe |
| mem_addr | output | 28 | Byte address for the memory read |
| mem_reg_sel | output | 1 | 1 selects the register space, 0 the array |
| mem_rdata | input | 8 | Byte returned MEM_LAT cycles after a strobe |

## Verification
A wrong header state, such as a miscounted address nibble or a missed ID compare, shows up in three places: a shifted `mem_addr` at the first strobe, a strobe that should not appear, or an enable that fires for a foreign ID. All of these appear within 2 to 5 cycles of the size nibble. A wrong response counter moves the sync or data nibbles by a cycle, and the per-cycle comparison of `bus_out` catches this in the turnaround or wait cycles. A wrong burst length or fetch phase returns wrong bytes or leaves the bus driven too long, which shows on the first affected byte or on the closing turnaround. The sweep covers every size code, both address spaces and every ID value, and each response cycle is compared.

// File: rtl/fwh_pkg.sv
`timescale 1ns/1ps
// Package: shared bus codes, header FSM encoding and size-code decode for the
// firmware-hub read target. Assumes a 4-bit bus and a 4-bit size field.
package fwh_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] NIB_START = 4'b1101;
    localparam logic [NIB_W-1:0] NIB_TURN  = 4'b1111;
    localparam logic [NIB_W-1:0] NIB_WAIT  = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;

    typedef enum logic [2:0] {
        HDR_IDLE,
        HDR_ID,
        HDR_ADDR,
        HDR_SIZE,
        HDR_SKIP
    } hdr_state_t;

    // Returns 1 for the sparse set of burst codes the target serves.
    function automatic logic size_code_ok(input logic [NIB_W-1:0] code,
                                          input int unsigned max_log2);
        logic known;
        known = (code == 4'd0) || (code == 4'd1) || (code == 4'd2) ||
                (code == 4'd4) || (code == 4'd7);
        return known && (int'(code) <= int'(max_log2));
    endfunction

endpackage

// File: rtl/fwh_hdr_decode.sv
`timescale 1ns/1ps
// Header decoder: follows the host-driven part of a read cycle (start, ID,
// address, size) and emits a one-cycle launch with an aligned, masked base
// address. Assumes the host holds frame_n low only in the start cycle; a low
// frame_n at any other time restarts or idles the decoder.
module fwh_hdr_decode
    import fwh_pkg::*;
#(
    parameter int          ADDR_W          = 28,
    parameter int          MAX_SIZE_LOG2   = 7,
    parameter int          ARRAY_SEL_BIT   = 22,
    parameter logic [27:0] ARRAY_KEEP_MASK = 28'h04F_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n,
    input  logic [NIB_W-1:0]     bus_in,
    input  logic [NIB_W-1:0]     id_strap,
    output logic                 launch,
    output logic [ADDR_W-1:0]    base_addr,
    output logic [NIB_W-1:0]     size_code,
    output logic                 reg_space
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int CNT_W     = $clog2(ADDR_NIBS);
    localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(ADDR_NIBS - 1);

    hdr_state_t             state_q;
    logic [CNT_W-1:0]       nib_cnt_q;
    logic [ADDR_W-1:0]      addr_sh_q;
    logic [ADDR_W-1:0]      space_addr;
    logic [ADDR_W-1:0]      align_mask;
    logic                   launch_q;
    logic [ADDR_W-1:0]      base_q;
    logic [NIB_W-1:0]       code_q;
    logic                   reg_q;

    // Purpose: apply the array-space mask and the burst alignment to the address.
    always_comb begin
        space_addr = addr_sh_q[ARRAY_SEL_BIT] ? (addr_sh_q & ARRAY_KEEP_MASK[ADDR_W-1:0])
                                              : addr_sh_q;
        align_mask = ~((ADDR_W'(1) << bus_in) - ADDR_W'(1));
    end

    // Purpose: header state machine with address shift and launch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= HDR_IDLE;
            nib_cnt_q <= '0;
            addr_sh_q <= '0;
            launch_q  <= 1'b0;
            base_q    <= '0;
            code_q    <= '0;
            reg_q     <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            if (!frame_n) begin
                state_q <= (bus_in == NIB_START) ? HDR_ID : HDR_IDLE;
            end else begin
                unique case (state_q)
                    HDR_IDLE: state_q <= HDR_IDLE;
                    HDR_ID: begin
                        nib_cnt_q <= '0;
                        state_q   <= (bus_in == id_strap) ? HDR_ADDR : HDR_SKIP;
                    end
                    HDR_ADDR: begin
                        addr_sh_q <= {addr_sh_q[ADDR_W-NIB_W-1:0], bus_in};
                        if (nib_cnt_q == LAST_NIB) begin
                            state_q <= HDR_SIZE;
                        end else begin
                            nib_cnt_q <= nib_cnt_q + 1'b1;
                        end
                    end
                    HDR_SIZE: begin
                        if (size_code_ok(bus_in, MAX_SIZE_LOG2)) begin
                            launch_q <= 1'b1;
                            base_q   <= space_addr & align_mask;
                            code_q   <= bus_in;
                            reg_q    <= ~addr_sh_q[ARRAY_SEL_BIT];
                            state_q  <= HDR_IDLE;
                        end else begin
                            state_q  <= HDR_SKIP;
                        end
                    end
                    HDR_SKIP: state_q <= HDR_SKIP;
                    default:  state_q <= HDR_IDLE;
                endcase
            end
        end
    end

    assign launch    = launch_q;
    assign base_addr = base_q;
    assign size_code = code_q;
    assign reg_space = reg_q;

endmodule

// File: rtl/fwh_resp_seq.sv
`timescale 1ns/1ps
// Response sequencer: after a launch, counts response cycles and chooses the
// nibble the target drives (turnaround, wait sync, ready sync, data, closing
// turnaround, release). Captures each memory byte as it arrives. Assumes the
// size code stays stable from launch to the end of the response.
module fwh_resp_seq
    import fwh_pkg::*;
#(
    parameter int MAX_SIZE_LOG2 = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n,
    input  logic                 launch,
    input  logic [NIB_W-1:0]     size_code,
    input  logic [7:0]           rdata,
    output logic                 active,
    output logic [$clog2(2*(1<<MAX_SIZE_LOG2)+8)-1:0] tcnt,
    output logic                 drv_oe,
    output logic [NIB_W-1:0]     drv_nib
);

    localparam int TCNT_W = $clog2(2*(1<<MAX_SIZE_LOG2)+8);

    logic                 active_q;
    logic [TCNT_W-1:0]    tcnt_q;
    logic [7:0]           byte_q;
    logic [TCNT_W-1:0]    two_n;
    logic [TCNT_W-1:0]    end_t;
    logic                 cap_en;

    // Purpose: derive burst-length dependent cycle limits.
    always_comb begin
        two_n  = TCNT_W'(2) << size_code;
        end_t  = TCNT_W'(6) + two_n;
        cap_en = active_q && (tcnt_q >= TCNT_W'(4)) && !tcnt_q[0] &&
                 (tcnt_q <= TCNT_W'(2) + two_n);
    end

    // Purpose: response cycle counter, cleared by an abort or at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            tcnt_q   <= '0;
        end else if (!frame_n) begin
            active_q <= 1'b0;
            tcnt_q   <= '0;
        end else if (launch) begin
            active_q <= 1'b1;
            tcnt_q   <= TCNT_W'(1);
        end else if (active_q) begin
            if (tcnt_q == end_t) begin
                active_q <= 1'b0;
                tcnt_q   <= '0;
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    // Purpose: hold the byte currently being serialised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (cap_en) begin
            byte_q <= rdata;
        end
    end

    // Purpose: select the driven nibble and enable for the current cycle.
    always_comb begin
        drv_oe  = 1'b0;
        drv_nib = NIB_TURN;
        if (active_q) begin
            if (tcnt_q == TCNT_W'(1)) begin
                drv_oe  = 1'b1;
                drv_nib = NIB_TURN;
            end else if (tcnt_q <= TCNT_W'(3)) begin
                drv_oe  = 1'b1;
                drv_nib = NIB_WAIT;
            end else if (tcnt_q == TCNT_W'(4)) begin
                drv_oe  = 1'b1;
                drv_nib = NIB_READY;
            end else if (tcnt_q <= TCNT_W'(4) + two_n) begin
                drv_oe  = 1'b1;
                drv_nib = tcnt_q[0] ? byte_q[3:0] : byte_q[7:4];
            end else if (tcnt_q == TCNT_W'(5) + two_n) begin
                drv_oe  = 1'b1;
                drv_nib = NIB_TURN;
            end
        end
    end

    assign active = active_q;
    assign tcnt   = tcnt_q;

endmodule

// File: rtl/fwh_mem_fetch.sv
`timescale 1ns/1ps
// Memory fetch: issues one read strobe per burst byte, timed so that each
// byte lands exactly in the cycle before it is serialised. Assumes
// 1 <= MEM_LAT <= 3 and an aligned base address.
module fwh_mem_fetch
    import fwh_pkg::*;
#(
    parameter int ADDR_W        = 28,
    parameter int MAX_SIZE_LOG2 = 7,
    parameter int MEM_LAT       = 2
) (
    input  logic                 active,
    input  logic [$clog2(2*(1<<MAX_SIZE_LOG2)+8)-1:0] tcnt,
    input  logic [NIB_W-1:0]     size_code,
    input  logic [ADDR_W-1:0]    base_addr,
    output logic                 rd_req,
    output logic [ADDR_W-1:0]    rd_addr
);

    localparam int TCNT_W = $clog2(2*(1<<MAX_SIZE_LOG2)+8);
    localparam logic [TCNT_W-1:0] FIRST_T = TCNT_W'(4 - MEM_LAT);

    logic [TCNT_W-1:0] rel;
    logic [TCNT_W-1:0] byte_idx;
    logic [TCNT_W-1:0] n_bytes;

    // Purpose: map the response cycle to a byte index and strobe decision.
    always_comb begin
        rel      = tcnt - FIRST_T;
        byte_idx = rel >> 1;
        n_bytes  = TCNT_W'(1) << size_code;
        rd_req   = active && (tcnt >= FIRST_T) && !rel[0] && (byte_idx < n_bytes);
        rd_addr  = base_addr + ADDR_W'(byte_idx);
    end

endmodule

// File: rtl/fwh_read_target.sv
`timescale 1ns/1ps
// Top: firmware-hub style read target. Joins the header decoder, response
// sequencer and memory fetch. Gates the drivers and the strobe with frame_n
// so an abort releases the bus in the same cycle. Assumes 1 <= MEM_LAT <= 3.
module fwh_read_target
    import fwh_pkg::*;
#(
    parameter int          ADDR_W          = 28,
    parameter int          MEM_LAT         = 2,
    parameter int          MAX_SIZE_LOG2   = 7,
    parameter int          ARRAY_SEL_BIT   = 22,
    parameter logic [27:0] ARRAY_KEEP_MASK = 28'h04F_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    input  logic [3:0]        id_strap,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_reg_sel,
    input  logic [7:0]        mem_rdata
);

    localparam int TCNT_W = $clog2(2*(1<<MAX_SIZE_LOG2)+8);

    logic                 launch;
    logic [ADDR_W-1:0]    base_addr;
    logic [NIB_W-1:0]     size_code;
    logic                 reg_space;
    logic                 active;
    logic [TCNT_W-1:0]    tcnt;
    logic                 drv_oe;
    logic [NIB_W-1:0]     drv_nib;
    logic                 rd_req;

    fwh_hdr_decode #(
        .ADDR_W          (ADDR_W),
        .MAX_SIZE_LOG2   (MAX_SIZE_LOG2),
        .ARRAY_SEL_BIT   (ARRAY_SEL_BIT),
        .ARRAY_KEEP_MASK (ARRAY_KEEP_MASK)
    ) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .bus_in    (bus_in),
        .id_strap  (id_strap),
        .launch    (launch),
        .base_addr (base_addr),
        .size_code (size_code),
        .reg_space (reg_space)
    );

    fwh_resp_seq #(
        .MAX_SIZE_LOG2 (MAX_SIZE_LOG2)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .launch    (launch),
        .size_code (size_code),
        .rdata     (mem_rdata),
        .active    (active),
        .tcnt      (tcnt),
        .drv_oe    (drv_oe),
        .drv_nib   (drv_nib)
    );

    fwh_mem_fetch #(
        .ADDR_W        (ADDR_W),
        .MAX_SIZE_LOG2 (MAX_SIZE_LOG2),
        .MEM_LAT       (MEM_LAT)
    ) u_fetch (
        .active    (active),
        .tcnt      (tcnt),
        .size_code (size_code),
        .base_addr (base_addr),
        .rd_req    (rd_req),
        .rd_addr   (mem_addr)
    );

    // Purpose: release drivers and strobe in the same cycle frame_n falls.
    always_comb begin
        bus_oe      = drv_oe & frame_n;
        bus_out     = drv_nib;
        mem_rd      = rd_req & frame_n;
        mem_reg_sel = reg_space;
    end

endmodule

// File: rtl/fwh_read_target_chk.sv
`timescale 1ns/1ps
// Checker: port-level temporal properties of the read target, bound to the top.
module fwh_read_target_chk #(
    parameter int          ADDR_W          = 28,
    parameter logic [27:0] ARRAY_KEEP_MASK = 28'h04F_FFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic [3:0]        bus_out,
    input logic              bus_oe,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_reg_sel
);

    // R7: the first driven cycle of a response carries the turnaround code.
    a_r7_first_drive_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !$past(bus_oe)) |-> (bus_out == 4'b1111));

    // R12: once frame_n has been low, the next cycle is not driven.
    a_r12_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !bus_oe);

    // R11: strobes are single-cycle and never back to back.
    a_r11_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R5: strobes two cycles apart address consecutive bytes.
    a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd, 2)) |-> (mem_addr == $past(mem_addr, 2) + 1'b1));

    // R6: array accesses present the ignored address bits as zero.
    a_r6_array_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_reg_sel) |->
            (((mem_addr & ~ARRAY_KEEP_MASK[ADDR_W-1:0]) == '0) && mem_addr[22]));

endmodule

bind fwh_read_target fwh_read_target_chk #(
    .ADDR_W          (ADDR_W),
    .ARRAY_KEEP_MASK (ARRAY_KEEP_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n     (frame_n),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .mem_reg_sel (mem_reg_sel)
);

// File: tb/tb_fwh_read_target.sv
`timescale 1ns/1ps
module tb_fwh_read_target;

    localparam int          LAT   = 2;
    localparam int          AW    = 28;
    localparam logic [3:0]  STRAP = 4'hA;
    localparam logic [27:0] KEEP  = 28'h04F_FFFF;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frame_n;
    logic [3:0]    bus_in;
    logic [3:0]    id_strap;
    logic [3:0]    bus_out;
    logic          bus_oe;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic          mem_reg_sel;
    logic [7:0]    mem_rdata;
    logic [7:0]    pipe [LAT];

    int errs   = 0;
    int checks = 0;

    always #10 clk = ~clk;

    fwh_read_target #(.ADDR_W(AW), .MEM_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
        .id_strap(id_strap), .bus_out(bus_out), .bus_oe(bus_oe),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_reg_sel(mem_reg_sel),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_val(input logic [27:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[27:24]} ^ {a[22], 7'h25};
    endfunction

    // Memory model with fixed read latency.
    always @(posedge clk) begin
        pipe[0] <= mem_val(mem_addr);
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign mem_rdata = pipe[LAT-1];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic [3:0] b);
        @(negedge clk);
        frame_n = f;
        bus_in  = b;
        #1;
    endtask

    task automatic quiet(input string req);
        chk(bus_oe == 1'b0, req, "bus_oe", bus_oe, 0);
        chk(mem_rd == 1'b0, req, "mem_rd", mem_rd, 0);
    endtask

    function automatic bit code_ok(input logic [3:0] c);
        return (c == 0) || (c == 1) || (c == 2) || (c == 4) || (c == 7);
    endfunction

    // Full or partial read; stop_after >= 0 ends after that response cycle.
    task automatic run_read(input logic [3:0] idv, input logic [27:0] a,
                            input logic [3:0] code, input int stop_after);
        logic [27:0] base;
        int n;
        int first;
        bit hit;
        hit = (idv == STRAP) && code_ok(code);
        step(1'b0, 4'b1101); quiet("R1");
        step(1'b1, idv);     quiet("R2");
        for (int i = 0; i < 7; i++) begin
            step(1'b1, a[27-4*i -: 4]); quiet("R3");
        end
        step(1'b1, code); quiet("R4");
        if (!hit) begin
            for (int i = 0; i < 20; i++) begin
                step(1'b1, (i % 3 == 0) ? 4'b1101 : 4'hF);
                quiet((idv != STRAP) ? "R2" : "R4");
            end
            return;
        end
        n     = 1 << code;
        base  = a[22] ? (a & KEEP) : a;
        base  = base & ~((28'd1 << code) - 28'd1);
        first = 4 - LAT;
        for (int t = 0; t <= 6 + 2*n; t++) begin
            logic       eoe;
            logic [3:0] enib;
            string      req;
            bit         erd;
            int         rel;
            if (stop_after >= 0 && t > stop_after) return;
            step(1'b1, 4'hF);
            eoe = 1'b1; enib = 4'hF; req = "R7";
            if (t == 0)             begin eoe = 1'b0; req = "R7"; end
            else if (t == 1)        begin enib = 4'hF; req = "R7"; end
            else if (t <= 3)        begin enib = 4'h5; req = "R8"; end
            else if (t == 4)        begin enib = 4'h0; req = "R8"; end
            else if (t <= 4 + 2*n) begin
                logic [7:0] bv;
                bv   = mem_val(base + 28'((t - 5) / 2));
                enib = (t % 2 == 1) ? bv[3:0] : bv[7:4];
                req  = "R9";
            end
            else if (t == 5 + 2*n)  begin enib = 4'hF; req = "R10"; end
            else                    begin eoe = 1'b0; req = "R10"; end
            chk(bus_oe == eoe, req, "bus_oe", bus_oe, eoe);
            if (eoe) chk(bus_out == enib, req, "bus_out", bus_out, enib);
            rel = t - first;
            erd = (t >= first) && (rel % 2 == 0) && (rel / 2 < n);
            chk(mem_rd == erd, "R11", "mem_rd", mem_rd, erd);
            if (erd && mem_rd) begin
                chk(mem_addr == base + 28'(rel / 2), "R5", "mem_addr", mem_addr,
                    base + 28'(rel / 2));
                chk(mem_reg_sel == ~a[22], "R6", "mem_reg_sel", mem_reg_sel, ~a[22]);
                if (a[22]) chk(mem_addr == (mem_addr & KEEP), "R6", "masked", mem_addr,
                               mem_addr & KEEP);
            end
        end
        step(1'b1, 4'hF); quiet("R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        frame_n  = 1'b1;
        bus_in   = 4'hF;
        id_strap = STRAP;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        quiet("R1");
        // R1: start code with frame high is not a start.
        step(1'b1, 4'b1101); quiet("R1");
        step(1'b1, STRAP);   quiet("R1");
        for (int i = 0; i < 10; i++) begin step(1'b1, 4'hF); quiet("R1"); end

        // R4 R5 R6 R9: every size code, register and array space.
        for (int c = 0; c < 16; c++) begin
            run_read(STRAP, 28'hABC_DEF5, 4'(c), -1);
            run_read(STRAP, 28'h5F7_3A9C, 4'(c), -1);
        end

        // R2 R13: every ID value, then a normal read afterwards.
        for (int id = 0; id < 16; id++) run_read(4'(id), 28'h5F7_3A9C, 4'd1, -1);
        run_read(STRAP, 28'h047_1234, 4'd2, -1);

        // R12: abort in the data phase without a new start.
        run_read(STRAP, 28'h5F7_3A9C, 4'd4, 9);
        step(1'b0, 4'h0); quiet("R12");
        for (int i = 0; i < 6; i++) begin step(1'b1, 4'hF); quiet("R12"); end

        // R12: abort in the wait phase with a new start, then the new read.
        run_read(STRAP, 28'hABC_DEF5, 4'd2, 3);
        run_read(STRAP, 28'h5F7_3A9C, 4'd0, -1);

        // R10: back-to-back reads.
        run_read(STRAP, 28'h0C0_0007, 4'd7, -1);
        run_read(STRAP, 28'h0C0_0011, 4'd1, -1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule